// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block turns a three-wire stereo audio stream (bit clock, frame clock, data) into parallel left and right PCM samples. It is a slave. The three serial lines are brought into the system clock domain through a synchronizer. The block acts only on rising edges of the bit clock. Because it never uses a free-running time base, the bit clock may stop and restart between bits.

A static format input selects the framing: I2S, left-justified, right-justified or DSP short-frame. A static width input selects 16, 20 or 24 bit samples. Narrower samples are left-aligned in a 24-bit output, and the unused low bits are zero. The block presents a left/right pair with a one-cycle strobe once the right word of a frame is complete.

When a frame-clock edge arrives before a full channel period has passed, the block realigns its bit counter to that edge. It then reports a one-cycle framing-error pulse and drops any left sample that is still waiting for its right partner.

Top module: `audrx_top`

## Requirements
- R1: While reset is high, and after it is released, `left_out`, `right_out`, `pair_valid` and `frame_err` are all zero until the first sample pair is delivered.
- R2: When `fmt` is 0 (I2S), the sample MSB is on the bit that follows the first bit on which the frame clock shows its new level. A frame-clock low period carries the left channel and a high period carries the right channel.
- R3: When `fmt` is 1 (left-justified), the MSB is on the first bit on which the frame clock shows its new level. The channel polarity is the same as in R2.
- R4: When `fmt` is 2 (right-justified), the LSB is on the 32nd bit of the channel period, which is the last bit before the next frame-clock edge. The MSB is on bit 32 minus the width, counting the first bit as 0.
- R5: When `fmt` is 3 (DSP), only a rising frame-clock edge starts a word, and the MSB is on the following bit. Words alternate left, then right. After reset or after a framing error, the first word is left. The level of the frame clock carries no channel meaning.
- R6: `wsel` 0 selects 16 bits, 1 selects 20 bits, and 2 or 3 select 24 bits. Samples are left-aligned in the 24-bit outputs, and the unused low bits are zero.
- R7: Only rising edges of `bclk` advance reception. Pauses of any length between bits, with the bit clock held low, do not change the received values.
- R8: A frame-clock edge that comes after fewer than 32 bits of the current channel period gives a one-cycle `frame_err` pulse and restarts the bit count at that edge. A left sample that has not yet been paired is discarded, so no pair is delivered for that frame.
- R9: Nothing is captured before the first frame-clock edge after reset. A right word that has no preceding left word in the same frame produces no output.
- R10: `pair_valid` is high for exactly one clock cycle per delivered pair. `left_out` and `right_out` change only in that cycle and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt | input | 2 | Framing select: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| wsel | input | 2 | Sample width select: 0 = 16, 1 = 20, 2 or 3 = 24 |
| bclk | input | 1 | Serial bit clock (asynchronous; may pause) |
| lrclk | input | 1 | Frame / channel clock |
| sdata | input | 1 | Serial audio data |
| left_out | output | 24 | Left sample, left-aligned |
| right_out | output | 24 | Right sample, left-aligned |
| pair_valid | output | 1 | One-cycle strobe when a pair is delivered |
| frame_err | output | 1 | One-cycle pulse on an early frame-clock edge |

## Verification
The embedded properties check, on every cycle, the properties that do not depend on stream content:
- the sample-pair strobe and the error pulse each last one cycle;
- both follow a bit-clock edge;
- the outputs hold between strobes;
- the padding bits are zero for the narrower widths.

Where the MSB and LSB land for each format, the left/right polarity and the DSP alternation can only be shown by the directed scenarios, which compare the delivered words against known serial patterns. The same holds for resynchronization after a short channel period, the dropped partial pair, and immunity to bit-clock pauses.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

    localparam int unsigned AUD_W    = 24;
    localparam int unsigned CH_SLOTS = 32;
    localparam int unsigned CNT_W    = $clog2(CH_SLOTS + 1);
    localparam int unsigned SH_W     = $clog2(AUD_W);

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_DSP = 2'd3
    } fmt_e;

    typedef struct packed {
        logic lr;
        logic dat;
    } bit_t;

    typedef struct packed {
        logic [AUD_W-1:0] left;
        logic [AUD_W-1:0] right;
    } pair_t;

    function automatic int unsigned width_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 20;
            default: return 24;
        endcase
    endfunction

    // Slot index (0 = first bit with new frame level) holding the MSB.
    function automatic int unsigned msb_slot(input fmt_e f, input int unsigned w);
        case (f)
            FMT_LJ:  return 0;
            FMT_RJ:  return CH_SLOTS - w;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/audrx_sync.sv
module audrx_sync
    import audrx_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic lrclk,
    input  logic sdata,
    output logic tick,
    output bit_t smp
);

    localparam int unsigned LINES = 3;

    logic [LINES-1:0] stage [STAGES];
    logic             bclk_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[g] <= '0;
            end else if (g == 0) begin
                stage[g] <= {bclk, lrclk, sdata};
            end else begin
                stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bclk_prev <= 1'b0;
        else     bclk_prev <= stage[STAGES-1][2];
    end

    always_comb begin
        tick    = stage[STAGES-1][2] & ~bclk_prev;
        smp.lr  = stage[STAGES-1][1];
        smp.dat = stage[STAGES-1][0];
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R7

endmodule

// File: rtl/audrx_framer.sv
module audrx_framer
    import audrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       lr_bit,
    input  fmt_e       fmt,
    input  logic [1:0] wsel,
    output logic       cap_en,
    output logic       word_done,
    output logic       word_ch,
    output logic       drop_left,
    output logic       frame_err
);

    logic [CNT_W-1:0] cnt_q, cnt_now, first_slot, last_slot;
    logic             prev_lr, synced_q, dch_q;
    logic             edge_seen, early, synced_now, ch_now;

    always_comb begin
        edge_seen  = (fmt == FMT_DSP) ? (lr_bit & ~prev_lr) : (lr_bit ^ prev_lr);
        early      = synced_q && edge_seen && (cnt_q < CNT_W'(CH_SLOTS - 1));
        if (edge_seen)                         cnt_now = '0;
        else if (cnt_q == CNT_W'(CH_SLOTS))    cnt_now = cnt_q;
        else                                   cnt_now = cnt_q + 1'b1;
        synced_now = synced_q | edge_seen;
        if (fmt != FMT_DSP)   ch_now = lr_bit;
        else if (edge_seen)   ch_now = (synced_q && !early) ? ~dch_q : 1'b0;
        else                  ch_now = dch_q;
        first_slot = CNT_W'(msb_slot(fmt, width_of(wsel)));
        last_slot  = first_slot + CNT_W'(width_of(wsel)) - 1'b1;
        cap_en     = tick && synced_now && (cnt_now >= first_slot) && (cnt_now <= last_slot);
        word_done  = tick && synced_now && (cnt_now == last_slot);
        word_ch    = ch_now;
        drop_left  = tick && early;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            prev_lr   <= 1'b0;
            synced_q  <= 1'b0;
            dch_q     <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            frame_err <= tick && early;
            if (tick) begin
                cnt_q    <= cnt_now;
                prev_lr  <= lr_bit;
                synced_q <= synced_now;
                dch_q    <= ch_now;
            end
        end
    end

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err); // R8
    AST_ERR_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> $past(tick)); // R8

endmodule

// File: rtl/audrx_shifter.sv
module audrx_shifter
    import audrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cap_en,
    input  logic             dat,
    input  logic             word_done,
    input  logic             word_ch,
    input  logic             drop_left,
    input  logic [1:0]       wsel,
    output logic [AUD_W-1:0] left_out,
    output logic [AUD_W-1:0] right_out,
    output logic             pair_valid
);

    logic [AUD_W-1:0] sh_q, sh_next, aligned, left_hold;
    logic             left_ok;
    logic [SH_W-1:0]  shamt;
    pair_t            pair_q;

    always_comb begin
        shamt   = SH_W'(AUD_W - width_of(wsel));
        sh_next = {sh_q[AUD_W-2:0], dat};
        aligned = sh_next << shamt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q       <= '0;
            left_hold  <= '0;
            left_ok    <= 1'b0;
            pair_q     <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (cap_en) sh_q <= sh_next;
            if (drop_left) left_ok <= 1'b0;
            if (word_done) begin
                if (!word_ch) begin
                    left_hold <= aligned;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    pair_q.left  <= left_hold;
                    pair_q.right <= aligned;
                    pair_valid   <= 1'b1;
                    left_ok      <= 1'b0;
                end
            end
        end
    end

    assign left_out  = pair_q.left;
    assign right_out = pair_q.right;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pair_valid |=> !pair_valid); // R10
    AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> $past(tick)); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |-> ($stable(left_out) && $stable(right_out))); // R10
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && wsel == 2'd0) |-> (left_out[7:0] == 8'd0 && right_out[7:0] == 8'd0)); // R6
    AST_PAD_ZERO_20: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && wsel == 2'd1) |-> (left_out[3:0] == 4'd0 && right_out[3:0] == 4'd0)); // R6

endmodule

// File: rtl/audrx_top.sv
module audrx_top
    import audrx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       fmt,
    input  logic [1:0]       wsel,
    input  logic             bclk,
    input  logic             lrclk,
    input  logic             sdata,
    output logic [AUD_W-1:0] left_out,
    output logic [AUD_W-1:0] right_out,
    output logic             pair_valid,
    output logic             frame_err
);

    logic tick, cap_en, word_done, word_ch, drop_left;
    bit_t smp;
    fmt_e fmt_sel;

    assign fmt_sel = fmt_e'(fmt);

    audrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .bclk  (bclk),
        .lrclk (lrclk),
        .sdata (sdata),
        .tick  (tick),
        .smp   (smp)
    );

    audrx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .lr_bit    (smp.lr),
        .fmt       (fmt_sel),
        .wsel      (wsel),
        .cap_en    (cap_en),
        .word_done (word_done),
        .word_ch   (word_ch),
        .drop_left (drop_left),
        .frame_err (frame_err)
    );

    audrx_shifter u_shifter (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cap_en     (cap_en),
        .dat        (smp.dat),
        .word_done  (word_done),
        .word_ch    (word_ch),
        .drop_left  (drop_left),
        .wsel       (wsel),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

endmodule

// File: tb/audrx_top_test.sv
module audrx_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  wsel = 2'd2;
    logic        bclk = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] left_out, right_out;
    logic        pair_valid, frame_err;

    int n_checks = 0;
    int n_errs   = 0;
    int vcount   = 0;
    int ecount   = 0;
    logic [23:0] got_l = '0, got_r = '0;

    always #10 clk = ~clk;

    audrx_top uut (
        .clk(clk), .rst(rst), .fmt(fmt), .wsel(wsel),
        .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
        .left_out(left_out), .right_out(right_out),
        .pair_valid(pair_valid), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (pair_valid) begin
                vcount++;
                got_l = left_out;
                got_r = right_out;
            end
            if (frame_err) ecount++;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] s);
        return (s == 2'd0) ? 16 : (s == 2'd1) ? 20 : 24;
    endfunction

    function automatic logic [23:0] trunc(input logic [23:0] v, input logic [1:0] s);
        int sh = 24 - wbits(s);
        return (v >> sh) << sh;
    endfunction

    task automatic drive_bit(input logic lr, input logic d, input int gap);
        @(negedge clk);
        lrclk = lr;
        sdata = d;
        repeat (4 + gap) @(negedge clk);
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
    endtask

    task automatic send_half(input logic ch, input logic [23:0] smp_v, input int gap);
        int w = wbits(wsel);
        int first = (fmt == 2'd1) ? 0 : (fmt == 2'd2) ? 32 - w : 1;
        for (int s = 0; s < 32; s++) begin
            int k = s - first;
            logic lr = (fmt == 2'd3) ? (s == 0) : ch;
            logic d  = (k >= 0 && k < w) ? smp_v[23-k] : 1'b0;
            drive_bit(lr, d, gap);
        end
    endtask

    task automatic prime();
        for (int s = 0; s < 32; s++) drive_bit((fmt == 2'd3) ? 1'b0 : 1'b1, 1'b0, 0);
    endtask

    task automatic do_reset(input logic [1:0] f, input logic [1:0] w);
        @(negedge clk);
        rst = 1'b1; bclk = 1'b0; lrclk = 1'b0; sdata = 1'b0;
        fmt = f; wsel = w;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_pair(input string req, input logic [23:0] l, input logic [23:0] r, input int gap);
        int base = vcount;
        send_half(1'b0, l, gap);
        send_half(1'b1, r, gap);
        repeat (12) @(negedge clk);
        check({req, " pair count"}, vcount - base, 1);
        check({req, " left"},  got_l, trunc(l, wsel));
        check({req, " right"}, got_r, trunc(r, wsel));
    endtask

    task automatic t_reset();
        do_reset(2'd0, 2'd2);
        check("R1 left after reset", left_out, 0);
        check("R1 right after reset", right_out, 0);
        check("R1 strobes after reset", {pair_valid, frame_err}, 0);
    endtask

    task automatic t_unsynced();
        int base;
        do_reset(2'd0, 2'd2);
        base = vcount;
        for (int s = 0; s < 80; s++) drive_bit(1'b0, 1'b1, 0);
        prime();
        repeat (12) @(negedge clk);
        check("R9 no pair before sync / without left", vcount - base, 0);
        check("R9 outputs untouched", left_out, 0);
    endtask

    task automatic t_i2s();
        do_reset(2'd0, 2'd2);
        prime();
        run_pair("R2 i2s 24 a", 24'hA5C3F1, 24'h123456, 0);
        run_pair("R2 i2s 24 b", 24'h800001, 24'h7FFFFE, 0);
        repeat (30) @(negedge clk);
        check("R10 left hold", left_out, 24'h800001);
        check("R10 right hold", right_out, 24'h7FFFFE);
    endtask

    task automatic t_lj();
        do_reset(2'd1, 2'd1);
        prime();
        run_pair("R3 R6 lj 20", 24'hF0F0FF, 24'h0BCDEF, 0);
        do_reset(2'd1, 2'd2);
        prime();
        run_pair("R3 lj 24", 24'h5A5A5A, 24'hC3C3C3, 0);
    endtask

    task automatic t_rj();
        do_reset(2'd2, 2'd0);
        prime();
        run_pair("R4 R6 rj 16", 24'hBEEFFF, 24'h1357AA, 0);
        do_reset(2'd2, 2'd3);
        prime();
        run_pair("R4 R6 rj 24 sel3", 24'h00FF01, 24'hFE0080, 0);
    endtask

    task automatic t_dsp();
        do_reset(2'd3, 2'd2);
        prime();
        run_pair("R5 dsp 24 a", 24'h9ABCDE, 24'h246801, 0);
        run_pair("R5 dsp 24 b", 24'h000001, 24'hFFFFFF, 0);
    endtask

    task automatic t_burst();
        do_reset(2'd0, 2'd0);
        prime();
        run_pair("R7 burst i2s 16", 24'hC0DE77, 24'h3E1F00, 7);
    endtask

    task automatic t_ferr();
        int vb, eb;
        do_reset(2'd0, 2'd2);
        prime();
        vb = vcount; eb = ecount;
        for (int s = 0; s < 20; s++) drive_bit(1'b0, 1'b1, 0);
        send_half(1'b1, 24'h111111, 0);
        repeat (12) @(negedge clk);
        check("R8 one error pulse", ecount - eb, 1);
        check("R8 broken pair dropped", vcount - vb, 0);
        run_pair("R8 recovery", 24'h765432, 24'hABCDEF, 0);
        check("R8 no further errors", ecount - eb, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        t_reset();
        t_unsynced();
        t_i2s();
        t_lj();
        t_rj();
        t_dsp();
        t_burst();
        t_ferr();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule